// File: doc/BRIEF.md
# Alarm, Watchdog and Interrupt Controller

This block merges three event sources into a single interrupt pin. The first source is a watchdog that counts down whole seconds from a programmed timeout. The second is a time-of-day alarm that compares four BCD fields (seconds, minutes, hours, day) against the current time from a timekeeping block. Each alarm field can be excluded from the comparison. The third source is a digital power-fail input.

Each source latches a sticky flag, and each flag has its own enable bit. Software reads the flags output and pulses a read strobe to clear them. The pin can be configured as active-high push-pull. It can also be configured as active-low open-drain, which is modelled as an output-enable that is asserted only while the line is pulled low.

Configuration goes through a small write port. The register at select 0 holds the watchdog timeout. Select 1 holds the source enables and the pin mode. Selects 2, 3, 4 and 5 hold the alarm fields.

Top module: `alarm_wdog_irq`

## Requirements
- R1: The pin signals an interrupt only when at least one source has both its flag and its enable bit set. Select 1 holds the enables: bit 0 for the alarm, bit 1 for power-fail and bit 2 for the watchdog.
- R2: The flags are sticky. On the flags output, bit 0 is the alarm, bit 1 is power-fail and bit 2 is the watchdog. A one-cycle pulse on flag_rd clears all flags. If a source sets its flag in the same cycle as the clear, the set wins. Changing the enable bits never clears a flag.
- R3: At select 0, bits 5:0 hold the watchdog timeout and bit 7 is a lock bit. A write with the lock bit at 0 loads the timeout and reloads the countdown with that value. A write with the lock bit at 1 leaves both the timeout and the countdown unchanged.
- R4: The countdown decrements once per sec_tick. The tick that takes it from 1 to 0 sets the watchdog flag. At 0 the countdown stays idle until it is reloaded, so a timeout of 0 never fires.
- R5: Selects 2, 3, 4 and 5 hold the alarm for seconds, minutes, hours and day. In each of these registers, bits 6:0 are the BCD value and bit 7 is an ignore bit (1 means the field is left out of the comparison). The alarm flag sets when every field that is not ignored equals the current time. At least one field must not be ignored.
- R6: The alarm responds to the start of a match. While a match persists, the flag does not set again after it has been cleared. A new match that begins later sets the flag again.
- R7: The power-fail flag sets in every cycle in which pf_in is high.
- R8: Pin modes are set at select 1: bit 3 selects push-pull and bit 4 selects open-drain. In push-pull mode, irq_oe is 1 and irq_out follows the interrupt. In open-drain mode only, irq_out is 0 and irq_oe follows the interrupt. With neither mode bit set, both outputs are 0. With both mode bits set, push-pull applies.
- R9: After reset, the flags, irq_out, irq_oe, the enables and the timeout are all 0, and every alarm field is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_day | input | 7 | Current day, BCD |
| pf_in | input | 1 | Power-fail indication |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select |
| wr_data | input | 8 | Register write data |
| flag_rd | input | 1 | Flags read strobe; clears the flags |
| flags | output | 3 | Sticky flags {watchdog, power-fail, alarm} |
| irq_out | output | 1 | Interrupt pin data |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The following properties are checked by assertions on every cycle:
- the pin never signals without an enabled flag behind it;
- a flag never drops unless the read strobe was pulsed;
- a locked watchdog write never alters the stored timeout;
- power-fail always raises its flag;
- open-drain mode never drives a high level.

The bench scenarios cover the behaviours that unfold over time: the countdown length and its reload, the alarm comparison under different ignore masks, the single set per match, and each pin mode.

// File: rtl/alarm_wdog_irq.sv
module alarm_wdog_irq #(
  parameter int TW = 6,
  parameter int FW = 7,
  parameter int NF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [FW-1:0] cur_sec,
  input  logic [FW-1:0] cur_min,
  input  logic [FW-1:0] cur_hour,
  input  logic [FW-1:0] cur_day,
  input  logic          pf_in,
  input  logic          wr_en,
  input  logic [2:0]    wr_sel,
  input  logic [7:0]    wr_data,
  input  logic          flag_rd,
  output logic [2:0]    flags,
  output logic          irq_out,
  output logic          irq_oe
);

  logic [TW-1:0] wd_to, wd_cnt;
  logic [2:0]    en_r, flags_r;
  logic          pp_r, od_r, match_q, alarm_match, wd_load, wd_hit, active;
  logic [FW-1:0] al_val [NF];
  logic [NF-1:0] al_ign;
  logic [FW-1:0] cur [NF];

  assign cur[0] = cur_sec;
  assign cur[1] = cur_min;
  assign cur[2] = cur_hour;
  assign cur[3] = cur_day;

  assign wd_load = wr_en && wr_sel == 3'd0 && !wr_data[7];
  assign wd_hit  = !wd_load && sec_tick && wd_cnt == TW'(1);

  always_comb begin
    logic eq, any;
    eq  = 1'b1;
    any = 1'b0;
    for (int i = 0; i < NF; i++) begin
      if (!al_ign[i]) begin
        any = 1'b1;
        if (al_val[i] != cur[i]) eq = 1'b0;
      end
    end
    alarm_match = any & eq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_to  <= '0;
      en_r   <= '0;
      pp_r   <= 1'b0;
      od_r   <= 1'b0;
      al_ign <= '1;
      for (int i = 0; i < NF; i++) al_val[i] <= '0;
    end else if (wr_en) begin
      if (wd_load) wd_to <= wr_data[TW-1:0];
      if (wr_sel == 3'd1) begin
        en_r <= wr_data[2:0];
        pp_r <= wr_data[3];
        od_r <= wr_data[4];
      end
      for (int i = 0; i < NF; i++) begin
        if (wr_sel == 3'(i + 2)) begin
          al_val[i] <= wr_data[FW-1:0];
          al_ign[i] <= wr_data[7];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_cnt  <= '0;
      match_q <= 1'b0;
      flags_r <= '0;
    end else begin
      if (wd_load) wd_cnt <= wr_data[TW-1:0];
      else if (sec_tick && wd_cnt != '0) wd_cnt <= wd_cnt - TW'(1);
      match_q <= alarm_match;
      flags_r <= (flag_rd ? 3'b000 : flags_r) | {wd_hit, pf_in, alarm_match & ~match_q};
    end
  end

  assign flags   = flags_r;
  assign active  = |(flags_r & en_r);
  assign irq_oe  = pp_r | (od_r & active);
  assign irq_out = pp_r & active;

endmodule

module alarm_wdog_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       flag_rd,
  input logic       pf_in,
  input logic       wr_en,
  input logic [2:0] wr_sel,
  input logic [7:0] wr_data,
  input logic [2:0] flags,
  input logic [2:0] src_en,
  input logic       pp,
  input logic       od,
  input logic [5:0] wd_to,
  input logic       irq_out,
  input logic       irq_oe
);

  a_r1_irq_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    ((pp && irq_out) || (!pp && irq_oe)) |-> (|(flags & src_en)));

  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_rd |=> ((flags & $past(flags)) == $past(flags)));

  a_r3_locked_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && wr_data[7]) |=> $stable(wd_to));

  a_r7_pf_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pf_in |=> flags[1]);

  a_r8_open_drain_low: assert property (@(posedge clk) disable iff (!rst_n)
    (od && !pp) |-> !irq_out);

endmodule

bind alarm_wdog_irq alarm_wdog_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flag_rd(flag_rd), .pf_in(pf_in),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .flags(flags),
  .src_en(en_r), .pp(pp_r), .od(od_r), .wd_to(wd_to),
  .irq_out(irq_out), .irq_oe(irq_oe)
);

// File: tb/test_alarm_wdog_irq.sv
module test_alarm_wdog_irq;
  logic       clk = 1'b0, rst_n = 1'b0, sec_tick = 1'b0, pf_in = 1'b0;
  logic [6:0] cur_sec = 7'h7F, cur_min = 7'h7F, cur_hour = 7'h7F, cur_day = 7'h7F;
  logic       wr_en = 1'b0, flag_rd = 1'b0;
  logic [2:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] flags;
  logic       irq_out, irq_oe;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  alarm_wdog_irq i_alarm_wdog_irq (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_day(cur_day),
    .pf_in(pf_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_rd(flag_rd), .flags(flags), .irq_out(irq_out), .irq_oe(irq_oe)
  );

  // ign[3:0] (bit0=sec), alarm sec,min,hour,day, current sec,min,hour,day, expected
  localparam logic [60:0] VEC [7] = '{
    {4'b1110, 7'h30, 7'h00, 7'h00, 7'h00, 7'h30, 7'h12, 7'h05, 7'h03, 1'b1},
    {4'b1110, 7'h30, 7'h00, 7'h00, 7'h00, 7'h31, 7'h12, 7'h05, 7'h03, 1'b0},
    {4'b1000, 7'h00, 7'h45, 7'h12, 7'h00, 7'h00, 7'h45, 7'h12, 7'h05, 1'b1},
    {4'b1000, 7'h00, 7'h45, 7'h12, 7'h00, 7'h00, 7'h45, 7'h13, 7'h05, 1'b0},
    {4'b0000, 7'h15, 7'h20, 7'h08, 7'h03, 7'h15, 7'h20, 7'h08, 7'h03, 1'b1},
    {4'b1111, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 7'h00, 1'b0},
    {4'b0101, 7'h00, 7'h59, 7'h00, 7'h07, 7'h11, 7'h59, 7'h22, 7'h07, 1'b1}
  };

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_clr();
    @(negedge clk); flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  task automatic park_time();
    @(negedge clk);
    cur_sec = 7'h7F; cur_min = 7'h7F; cur_hour = 7'h7F; cur_day = 7'h7F;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(flags == 3'b000, "R9 flags", 8'(flags), 8'h0);
    check(irq_out == 1'b0 && irq_oe == 1'b0, "R9 pin", {6'b0, irq_out, irq_oe}, 8'h0);
    cur_sec = 7'h00; cur_min = 7'h00; cur_hour = 7'h00; cur_day = 7'h00;
    repeat (2) @(negedge clk);
    check(flags[0] == 1'b0, "R9 alarm fields ignored", 8'(flags), 8'h0);

    // R5 alarm comparison table
    for (int v = 0; v < 7; v++) begin
      logic [60:0] t;
      t = VEC[v];
      park_time();
      wr(3'd2, {t[57], t[56:50]});
      wr(3'd3, {t[58], t[49:43]});
      wr(3'd4, {t[59], t[42:36]});
      wr(3'd5, {t[60], t[35:29]});
      rd_clr();
      cur_sec = t[28:22]; cur_min = t[21:15]; cur_hour = t[14:8]; cur_day = t[7:1];
      @(negedge clk);
      check(flags[0] == t[0], $sformatf("R5 vector %0d", v), 8'(flags[0]), 8'(t[0]));
    end

    // R6 edge detection
    park_time();
    wr(3'd2, 8'h10); wr(3'd3, 8'h80); wr(3'd4, 8'h80); wr(3'd5, 8'h80);
    rd_clr();
    cur_sec = 7'h10;
    @(negedge clk);
    check(flags[0] == 1'b1, "R6 match start", 8'(flags), 8'h1);
    rd_clr();
    repeat (3) @(negedge clk);
    check(flags[0] == 1'b0, "R6 held match no reset", 8'(flags), 8'h0);
    cur_sec = 7'h11;
    @(negedge clk);
    cur_sec = 7'h10;
    @(negedge clk);
    check(flags[0] == 1'b1, "R6 new match", 8'(flags), 8'h1);
    park_time();
    wr(3'd2, 8'h80);
    rd_clr();

    // R7 power-fail and R2 stickiness
    @(negedge clk); pf_in = 1'b1;
    @(negedge clk); pf_in = 1'b0;
    check(flags == 3'b010, "R7 pf sets", 8'(flags), 8'h2);
    repeat (2) @(negedge clk);
    check(flags == 3'b010, "R2 sticky", 8'(flags), 8'h2);
    @(negedge clk); pf_in = 1'b1; flag_rd = 1'b1;
    @(negedge clk); flag_rd = 1'b0;
    check(flags[1] == 1'b1, "R2 set wins over clear", 8'(flags), 8'h2);
    pf_in = 1'b0;

    // R8 / R1 pin modes
    wr(3'd1, 8'b0000_1010);
    check(irq_out == 1'b1 && irq_oe == 1'b1, "R8 push-pull active", {6'b0, irq_out, irq_oe}, 8'h3);
    wr(3'd1, 8'b0000_1000);
    check(irq_out == 1'b0 && irq_oe == 1'b1, "R1 disabled source", {6'b0, irq_out, irq_oe}, 8'h1);
    check(flags[1] == 1'b1, "R2 enable change keeps flag", 8'(flags), 8'h2);
    wr(3'd1, 8'b0001_0010);
    check(irq_out == 1'b0 && irq_oe == 1'b1, "R8 open-drain active", {6'b0, irq_out, irq_oe}, 8'h1);
    wr(3'd1, 8'b0001_0101);
    check(irq_out == 1'b0 && irq_oe == 1'b0, "R1 other enables only", {6'b0, irq_out, irq_oe}, 8'h0);
    wr(3'd1, 8'b0000_0010);
    check(irq_out == 1'b0 && irq_oe == 1'b0, "R8 no mode", {6'b0, irq_out, irq_oe}, 8'h0);
    wr(3'd1, 8'b0001_1010);
    check(irq_out == 1'b1 && irq_oe == 1'b1, "R8 both modes", {6'b0, irq_out, irq_oe}, 8'h3);
    rd_clr();
    check(irq_out == 1'b0 && irq_oe == 1'b1, "R1 cleared flag", {6'b0, irq_out, irq_oe}, 8'h1);

    // R3 / R4 watchdog
    wr(3'd1, 8'b0000_1100);
    wr(3'd0, 8'h03);
    tick(2);
    check(flags[2] == 1'b0, "R4 before timeout", 8'(flags), 8'h0);
    tick(1);
    check(flags[2] == 1'b1 && irq_out == 1'b1, "R4 timeout", {4'b0, flags, irq_out}, 8'h9);
    rd_clr();
    tick(3);
    check(flags[2] == 1'b0, "R4 idle at zero", 8'(flags), 8'h0);
    wr(3'd0, 8'h03);
    tick(2);
    wr(3'd0, 8'h03);
    tick(2);
    check(flags[2] == 1'b0, "R3 reload on write", 8'(flags), 8'h0);
    tick(1);
    check(flags[2] == 1'b1, "R3 reloaded timeout", 8'(flags), 8'h4);
    rd_clr();
    wr(3'd0, 8'h82);
    tick(3);
    check(flags[2] == 1'b0, "R3 locked write ignored", 8'(flags), 8'h0);
    wr(3'd0, 8'h02);
    tick(2);
    check(flags[2] == 1'b1, "R3 unlocked write", 8'(flags), 8'h4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule